// File: doc/BRIEF.md
# Program Fetch Wait-State Manager

This block sits between a CPU instruction-fetch port and three program memory regions. It sorts each 16-bit fetch or program-write address into one of three regions. A low on-chip ROM region starts at address zero. A high on-chip RAM region ends at the top of the map. Everything between the two goes to off-chip memory. Two size buses set the region boundaries at run time. A size of zero removes a region, and a size of 65536 lets a region cover the whole map.

On-chip accesses finish without stalling the CPU. Off-chip accesses are held for a wait count that software programs through a small write port. An external ready input can stretch the access further, and it may change from cycle to cycle. The block selects the read byte for the region captured when the access began. It steers program writes either to the on-chip RAM write strobe or to the external program-write strobe. A small state machine sequences the off-chip accesses:
- ST_IDLE accepts requests.
- ST_COUNT runs down the programmed wait count.
- ST_HOLD waits for ready.

The transitions are:
- ST_IDLE to ST_COUNT: an off-chip request while the wait count is not zero.
- ST_IDLE to ST_HOLD: an off-chip request while the wait count is zero.
- ST_COUNT to ST_HOLD: the counter reaches its last wait cycle.
- ST_HOLD to ST_IDLE: ready is high.

Top module: `pfetch_wait_mgr`

## Requirements
- R1: An address below `rom_size` decodes to on-chip ROM. A read there raises no stall and no external strobe, and in the cycle after it is accepted `cpu_rdata` equals `rom_rdata`.
- R2: An address that is not in ROM and is at or above 65536 minus `ram_size` decodes to on-chip RAM. A read there raises no stall, and in the next cycle `cpu_rdata` equals `ram_rdata`.
- R3: Every other address is off-chip. A read there raises `ext_rd` and `cpu_stall` in the request cycle.
- R4: When `rom_size` plus `ram_size` exceeds 65536, addresses that fall in both regions decode to ROM.
- R5: With `ext_ready` held high, an off-chip access stalls for exactly W+1 cycles, where W is the programmed wait count. That is one setup cycle in ST_IDLE plus W cycles in ST_COUNT.
- R6: The cycles of an off-chip access are numbered from 0, counting from the request cycle. The access completes (stall low) in the first cycle numbered W+1 or later in which `ext_ready` is high. A low `ext_ready` never ends a stall.
- R7: The wait count is 3 bits wide and resets to 7. A cycle with `ws_wr` high loads `ws_wdata`, and without `ws_wr` the count does not change.
- R8: The read byte is held after the access. For off-chip reads it is the `ext_rdata` value present in the completing cycle. It does not follow later changes of `cpu_addr` or `ext_rdata`.
- R9: A write to RAM pulses `ram_we` for one cycle with no stall. An off-chip write asserts `ext_wr` with the same stall timing as a read. A write to ROM raises no strobe and no stall. If `cpu_wr` and `cpu_rd` are both high, the request is treated as a write.
- R10: After reset, and whenever there is no request, `cpu_stall`, `ext_rd`, `ext_wr` and `ram_we` are low. `ext_rd` and `ext_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Fetch or program-write address, held while stalled |
| cpu_rd | input | 1 | Fetch request |
| cpu_wr | input | 1 | Program-write request |
| cpu_rdata | output | 8 | Selected read byte, valid the cycle after completion |
| cpu_stall | output | 1 | Holds the CPU while an off-chip access runs |
| rom_size | input | 17 | Size of the on-chip ROM region in bytes (0 to 65536) |
| ram_size | input | 17 | Size of the on-chip RAM region in bytes (0 to 65536) |
| ws_wr | input | 1 | Load strobe for the wait count |
| ws_wdata | input | 3 | New wait count |
| rom_rdata | input | 8 | Read data from on-chip ROM |
| ram_rdata | input | 8 | Read data from on-chip RAM |
| ext_rdata | input | 8 | Read data from off-chip memory |
| ext_ready | input | 1 | Off-chip memory ready |
| ram_we | output | 1 | On-chip RAM program-write strobe |
| ext_rd | output | 1 | Off-chip program read strobe |
| ext_wr | output | 1 | Off-chip program write strobe |

## Verification
Some properties are checked by assertions on every cycle:
- the two external strobes never overlap;
- a stall always has an external strobe behind it;
- a stall never ends while ready is low;
- on-chip requests never stall;
- a RAM write never coincides with a stall;
- the wait count only changes on a load.

Other behaviours need the bench's scenarios. These are the exact number of stall cycles for each wait count and ready pattern, the decoded region at each boundary and overlap, the reset value of the count, and the byte returned after each access. The bench sweeps boundary addresses over several size pairs, every wait count and several ready patterns, and computes each expected value arithmetically.

// File: rtl/pfw_pkg.sv
package pfw_pkg;
    typedef enum logic [1:0] {
        RG_ROM = 2'd0,
        RG_RAM = 2'd1,
        RG_EXT = 2'd2
    } region_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_HOLD  = 2'd2
    } state_t;
endpackage

// File: rtl/pfw_region_dec.sv
module pfw_region_dec
    import pfw_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW:0]   rom_size,
    input  logic [AW:0]   ram_size,
    output region_t       region
);
    localparam logic [AW:0] SPAN = {1'b1, {AW{1'b0}}};

    logic [AW:0] addr_w;
    logic [AW:0] ram_base;

    always_comb begin
        addr_w   = {1'b0, addr};
        ram_base = (ram_size >= SPAN) ? '0 : (SPAN - ram_size);
        if (addr_w < rom_size)
            region = RG_ROM;
        else if (addr_w >= ram_base)
            region = RG_RAM;
        else
            region = RG_EXT;
    end
endmodule

// File: rtl/pfw_wait_ctr.sv
module pfw_wait_ctr #(
    parameter int WSW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [WSW-1:0] cfg_val,
    input  logic           load,
    input  logic           dec,
    output logic [WSW-1:0] ws_q,
    output logic [WSW-1:0] cnt_q
);
    localparam logic [WSW-1:0] WS_RESET = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ws_q <= WS_RESET;
        else if (cfg_we)
            ws_q <= cfg_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= ws_q;
        else if (dec && (cnt_q != '0))
            cnt_q <= cnt_q - WSW'(1);
    end
endmodule

// File: rtl/pfw_rdata_sel.sv
module pfw_rdata_sel
    import pfw_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_sel,
    input  region_t       sel_in,
    input  logic          take_ext,
    input  logic [DW-1:0] ext_in,
    input  logic [DW-1:0] rom_in,
    input  logic [DW-1:0] ram_in,
    output logic [DW-1:0] rdata
);
    region_t       sel_q;
    logic [DW-1:0] ext_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= RG_ROM;
            ext_q <= '0;
        end else begin
            if (take_sel)
                sel_q <= sel_in;
            if (take_ext)
                ext_q <= ext_in;
        end
    end

    always_comb begin
        unique case (sel_q)
            RG_ROM:  rdata = rom_in;
            RG_RAM:  rdata = ram_in;
            RG_EXT:  rdata = ext_q;
            default: rdata = rom_in;
        endcase
    end
endmodule

// File: rtl/pfetch_wait_mgr.sv
module pfetch_wait_mgr
    import pfw_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 8,
    parameter int WSW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    output logic [DW-1:0] cpu_rdata,
    output logic          cpu_stall,
    input  logic [AW:0]   rom_size,
    input  logic [AW:0]   ram_size,
    input  logic          ws_wr,
    input  logic [WSW-1:0] ws_wdata,
    input  logic [DW-1:0] rom_rdata,
    input  logic [DW-1:0] ram_rdata,
    input  logic [DW-1:0] ext_rdata,
    input  logic          ext_ready,
    output logic          ram_we,
    output logic          ext_rd,
    output logic          ext_wr
);
    localparam logic [WSW-1:0] CNT_LAST = WSW'(1);

    state_t         state_q, state_d;
    region_t        region;
    logic           wr_q;
    logic           req, off_req, ld_cnt, dec_cnt, take_sel, take_ext;
    logic [WSW-1:0] ws_q, cnt_q;

    pfw_region_dec #(.AW(AW)) u_dec (
        .addr     (cpu_addr),
        .rom_size (rom_size),
        .ram_size (ram_size),
        .region   (region)
    );

    pfw_wait_ctr #(.WSW(WSW)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (ws_wr),
        .cfg_val (ws_wdata),
        .load    (ld_cnt),
        .dec     (dec_cnt),
        .ws_q    (ws_q),
        .cnt_q   (cnt_q)
    );

    pfw_rdata_sel #(.DW(DW)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_sel (take_sel),
        .sel_in   (region),
        .take_ext (take_ext),
        .ext_in   (ext_rdata),
        .rom_in   (rom_rdata),
        .ram_in   (ram_rdata),
        .rdata    (cpu_rdata)
    );

    assign req     = cpu_rd | cpu_wr;
    assign off_req = req && (region == RG_EXT);

    // state register and write-type capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ld_cnt)
                wr_q <= cpu_wr;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (off_req) state_d = (ws_q == '0) ? ST_HOLD : ST_COUNT;
            ST_COUNT: if (cnt_q == CNT_LAST) state_d = ST_HOLD;
            ST_HOLD:  if (ext_ready) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cpu_stall = 1'b0;
        ext_rd    = 1'b0;
        ext_wr    = 1'b0;
        ram_we    = 1'b0;
        ld_cnt    = 1'b0;
        dec_cnt   = 1'b0;
        take_sel  = 1'b0;
        take_ext  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cpu_stall = off_req;
                ext_rd    = off_req && !cpu_wr;
                ext_wr    = off_req && cpu_wr;
                ram_we    = cpu_wr && (region == RG_RAM);
                ld_cnt    = off_req;
                take_sel  = cpu_rd && !cpu_wr;
            end
            ST_COUNT: begin
                cpu_stall = 1'b1;
                ext_rd    = !wr_q;
                ext_wr    = wr_q;
                dec_cnt   = 1'b1;
            end
            ST_HOLD: begin
                cpu_stall = !ext_ready;
                ext_rd    = !wr_q;
                ext_wr    = wr_q;
                take_ext  = ext_ready && !wr_q;
            end
            default: cpu_stall = 1'b0;
        endcase
    end
endmodule

// File: rtl/pfw_wait_mgr_chk.sv
module pfw_wait_mgr_chk
    import pfw_pkg::*;
#(
    parameter int WSW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cpu_rd,
    input logic           cpu_wr,
    input logic           ext_ready,
    input logic           ws_wr,
    input logic           cpu_stall,
    input logic           ext_rd,
    input logic           ext_wr,
    input logic           ram_we,
    input state_t         state_q,
    input region_t        region,
    input logic [WSW-1:0] ws_q
);
    a_r10_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_rd && ext_wr));

    a_r3_stall_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_stall |-> (ext_rd || ext_wr));

    a_r6_low_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_ready && $past(cpu_stall)) |-> cpu_stall);

    a_r1_onchip_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && (cpu_rd || cpu_wr) && region != RG_EXT) |-> !cpu_stall);

    a_r9_ram_we_alone: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (!cpu_stall && !ext_wr && !ext_rd));

    a_r7_ws_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        !ws_wr |=> $stable(ws_q));
endmodule

bind pfetch_wait_mgr pfw_wait_mgr_chk #(.WSW(WSW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .ext_ready (ext_ready),
    .ws_wr     (ws_wr),
    .cpu_stall (cpu_stall),
    .ext_rd    (ext_rd),
    .ext_wr    (ext_wr),
    .ram_we    (ram_we),
    .state_q   (state_q),
    .region    (region),
    .ws_q      (ws_q)
);

// File: tb/pfetch_wait_mgr_tb.sv
module pfetch_wait_mgr_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 16;
    localparam int DW  = 8;
    localparam int WSW = 3;
    localparam logic [7:0] ROM_BYTE = 8'h5A;
    localparam logic [7:0] RAM_BYTE = 8'hC3;
    localparam logic [31:0] ALL_READY = 32'hFFFF_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_rd = 1'b0;
    logic          cpu_wr = 1'b0;
    logic [DW-1:0] cpu_rdata;
    logic          cpu_stall;
    logic [AW:0]   rom_size = '0;
    logic [AW:0]   ram_size = '0;
    logic          ws_wr = 1'b0;
    logic [WSW-1:0] ws_wdata = '0;
    logic [DW-1:0] rom_rdata = ROM_BYTE;
    logic [DW-1:0] ram_rdata = RAM_BYTE;
    logic [DW-1:0] ext_rdata = '0;
    logic          ext_ready = 1'b1;
    logic          ram_we, ext_rd, ext_wr;

    int n_checks = 0;
    int n_errors = 0;
    int ws_cur = 7;
    int cur_rs = 0;
    int cur_ms = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pfetch_wait_mgr #(.AW(AW), .DW(DW), .WSW(WSW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall), .rom_size(rom_size), .ram_size(ram_size),
        .ws_wr(ws_wr), .ws_wdata(ws_wdata), .rom_rdata(rom_rdata), .ram_rdata(ram_rdata),
        .ext_rdata(ext_rdata), .ext_ready(ext_ready), .ram_we(ram_we), .ext_rd(ext_rd),
        .ext_wr(ext_wr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int region_of(input int a);
        if (a < cur_rs) return 0;
        if (a >= 65536 - cur_ms) return 1;
        return 2;
    endfunction

    function automatic int exp_stalls(input int ws, input logic [31:0] pat);
        for (int i = ws + 1; i < 32; i++)
            if (pat[i]) return i;
        return 32;
    endfunction

    task automatic set_sizes(input int rs, input int ms);
        @(negedge clk);
        rom_size = 17'(rs);
        ram_size = 17'(ms);
        cur_rs = rs;
        cur_ms = ms;
    endtask

    task automatic set_ws(input int w);
        @(negedge clk);
        ws_wr = 1'b1;
        ws_wdata = 3'(w);
        @(negedge clk);
        ws_wr = 1'b0;
        ws_cur = w;
    endtask

    task automatic do_read(input int a, input logic [31:0] pat, input string tag);
        int rg;
        int n;
        int expd;
        logic [7:0] xb;
        logic [7:0] eb;
        rg = region_of(a);
        n = 0;
        xb = 8'(a) ^ 8'h3C;
        @(negedge clk);
        cpu_addr = 16'(a);
        cpu_rd = 1'b1;
        ext_rdata = xb;
        ext_ready = pat[0];
        #1;
        chk(ext_rd == (rg == 2), {tag, " ext_rd at request"}, int'(ext_rd), int'(rg == 2));
        while (cpu_stall && n < 40) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            ext_ready = (n < 32) ? pat[n] : 1'b1;
            #1;
        end
        expd = (rg == 2) ? exp_stalls(ws_cur, pat) : 0;
        chk(n == expd, {tag, " stall cycles"}, n, expd);
        @(posedge clk);
        @(negedge clk);
        cpu_rd = 1'b0;
        ext_ready = 1'b1;
        ext_rdata = ~xb;
        cpu_addr = 16'(a) ^ 16'h8000;
        #1;
        eb = (rg == 0) ? ROM_BYTE : (rg == 1) ? RAM_BYTE : xb;
        chk(cpu_rdata == eb, {tag, " R8 read byte"}, int'(cpu_rdata), int'(eb));
    endtask

    task automatic do_write(input int a, input string tag);
        int rg;
        int n;
        int expd;
        rg = region_of(a);
        n = 0;
        @(negedge clk);
        cpu_addr = 16'(a);
        cpu_wr = 1'b1;
        ext_ready = 1'b1;
        #1;
        chk(ram_we == (rg == 1), {tag, " ram_we"}, int'(ram_we), int'(rg == 1));
        chk(ext_wr == (rg == 2), {tag, " ext_wr"}, int'(ext_wr), int'(rg == 2));
        while (cpu_stall && n < 40) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            #1;
        end
        expd = (rg == 2) ? ws_cur + 1 : 0;
        chk(n == expd, {tag, " write stall cycles"}, n, expd);
        @(posedge clk);
        @(negedge clk);
        cpu_wr = 1'b0;
        #1;
        chk(!ram_we && !ext_wr && !cpu_stall, {tag, " strobes idle after write"},
            int'({ram_we, ext_wr, cpu_stall}), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL R10 watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        int rs_l[5];
        int ms_l[5];
        int al[7];
        logic [31:0] pats[5];
        string tg;

        rs_l = '{32'h0400, 0, 32'h10000, 32'hC000, 0};
        ms_l = '{32'h1000, 0, 0, 32'h8000, 32'h10000};

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: quiet outputs after reset with no request
        chk(!cpu_stall, "R10 reset stall", int'(cpu_stall), 0);
        chk(!ext_rd && !ext_wr && !ram_we, "R10 reset strobes",
            int'({ext_rd, ext_wr, ram_we}), 0);

        // R7: reset wait count is 7, so 8 stall cycles
        set_sizes(32'h0400, 32'h1000);
        ws_cur = 7;
        do_read(32'h2000, ALL_READY, "R7 reset wait count");

        // R1 R2 R3 R4: boundary sweep over size pairs
        set_ws(2);
        for (int ci = 0; ci < 5; ci++) begin
            set_sizes(rs_l[ci], ms_l[ci]);
            al = '{0, cur_rs - 1, cur_rs, 65535 - cur_ms, 65536 - cur_ms, 65535, 32'h7FFF};
            for (int k = 0; k < 7; k++) begin
                if (al[k] >= 0 && al[k] <= 65535) begin
                    if (ci == 3) tg = "R4 overlap";
                    else if (region_of(al[k]) == 0) tg = "R1 rom";
                    else if (region_of(al[k]) == 1) tg = "R2 ram";
                    else tg = "R3 offchip";
                    do_read(al[k], ALL_READY, tg);
                end
            end
        end

        // R5: every wait count with ready held high
        set_sizes(32'h0400, 32'h1000);
        for (int w = 0; w < 8; w++) begin
            set_ws(w);
            do_read(32'h3000 + w, ALL_READY, "R5 wait count");
        end

        // R6: ready patterns stretching the access
        set_ws(3);
        pats = '{32'hFFFF_FF00, 32'hAAAA_AAAA, 32'h8000_0000, 32'hFFFF_FFEF, 32'hFFFF_FFF0};
        for (int p = 0; p < 5; p++)
            do_read(32'h4100 + p, pats[p], "R6 ready stretch");
        set_ws(0);
        do_read(32'h4200, 32'hFFFF_FFF8, "R6 ready stretch zero wait");

        // R9: program writes into each region
        set_ws(2);
        do_write(32'hF800, "R9 ram write");
        do_write(32'h0100, "R9 rom write ignored");
        do_write(32'h5000, "R9 offchip write");
        do_write(32'hFFFF, "R9 ram top write");
        do_read(32'hF810, ALL_READY, "R8 read after writes");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule